// File: doc/BRIEF.md
# Bus Receive Framer with Parity Check

This block sits on the receive side of one unit attached to a wide, time-multiplexed command/address/data bus. Every line it watches is active low. On each falling clock edge it samples a start strobe, a burst strobe, a control-parity line, the data bus and one parity line per byte lane. It then rebuilds the transfer as a stream of words. The first word of every transaction carries a first marker, because it holds the command or answer. The words that follow are data. The final word carries a last marker.

The end of a transfer is inferred from the burst strobe. A transaction begins with the start strobe. It continues while the burst strobe is held. The word in which the burst strobe is seen deasserted is the final one. Odd parity is checked on every byte lane, and on the pair of framing strobes, but only in cycles that carry a word.

Parity failures are gathered into one error flag per transaction, which is presented with the last word. A start strobe that interrupts an open burst raises a separate framing flag. The block does not decode commands and does not drive the bus.

Top module: `brx_framer`

## Requirements
- R1: While reset is asserted, and after it is released with no start strobe seen, `wd_valid`, `wd_first`, `wd_last`, `wd_err` and `wd_frame_err` are low.
- R2: A framed word appears on `wd_data` as the bit-inverse of `bus_n`, with `wd_valid` high. It shows up at the same falling edge that sampled it and holds until the next falling edge.
- R3: A word sampled with `sof_n` low is marked `wd_first`. If `bst_n` is high in that cycle, the word is also `wd_last`: a single-word transaction.
- R4: After a first word sampled with `bst_n` low, each later cycle yields a valid word that is not first. The first cycle in which `bst_n` is sampled high yields the last word, and framing then stops.
- R5: Lane i is `bus_n[8i+7:8i]` with parity line `bpar_n[i]`. After inversion, the lane's eight bits plus its parity bit must hold an odd number of ones; an even count is a parity failure.
- R6: After inversion, the start strobe, the burst strobe and `cpar_n` must together hold an odd number of ones; an even count is a parity failure.
- R7: A parity failure in any word of a transaction raises `wd_err` on that transaction's last word and on no other word. A new start strobe clears it.
- R8: A start strobe sampled while a burst is open raises `wd_frame_err` together with `wd_first`. The new transaction is then framed normally.
- R9: In cycles with no open burst and no start strobe, `wd_valid` stays low. Parity lines and a stray burst strobe in such cycles have no effect on any later transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Bus clock; all sampling on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_n | input | 1 | Start strobe, active low, first cycle of a transaction |
| bst_n | input | 1 | Burst strobe, active low, held while more words follow |
| cpar_n | input | 1 | Control parity over the two strobes, active low |
| bus_n | input | DATA_W | Command/address/data bus, active low |
| bpar_n | input | DATA_W/LANE_W | Per-lane odd parity, active low |
| wd_valid | output | 1 | A framed word is presented |
| wd_first | output | 1 | Word is the command or answer word |
| wd_last | output | 1 | Word is the final word of the transaction |
| wd_data | output | DATA_W | Framed word, true polarity |
| wd_err | output | 1 | Transaction saw a parity failure (on last word) |
| wd_frame_err | output | 1 | Start strobe arrived inside an open burst |

## Verification
The bench builds the block with its default widths: a 64-bit bus split into eight byte lanes. At that size both edge lanes (0 and 7) can be corrupted, as well as a middle lane. Transfers of one, three and four words cover the single-word case, the end-of-burst inference and error accumulation across several words. An interrupted burst and garbage on an idle bus complete the framing corner cases.

// File: rtl/brx_pkg.sv
package brx_pkg;
  typedef enum logic {
    FR_IDLE = 1'b0,
    FR_OPEN = 1'b1
  } fr_state_e;
endpackage

// File: rtl/brx_par_chk.sv
module brx_par_chk #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  localparam int NLANES = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] data,
  input  logic [NLANES-1:0] lane_par,
  input  logic              sof,
  input  logic              bst,
  input  logic              ctl_par,
  output logic              word_bad
);
  logic [NLANES-1:0] lane_bad;
  logic              ctl_bad;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    // odd parity: lane plus its parity bit must carry an odd count of ones
    assign lane_bad[g] = ~(^{data[g*LANE_W +: LANE_W], lane_par[g]});
  end

  assign ctl_bad  = ~(sof ^ bst ^ ctl_par);
  assign word_bad = ctl_bad | (|lane_bad);
endmodule

// File: rtl/brx_seq.sv
module brx_seq
  import brx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sof,
  input  logic bst,
  input  logic word_bad,
  output logic take,
  output logic first,
  output logic last,
  output logic err,
  output logic frame_err
);
  fr_state_e state_q, state_d;
  logic      acc_q, acc_d;
  logic      err_now;

  always_comb begin
    take      = sof | (state_q == FR_OPEN);
    first     = sof;
    last      = take & ~bst;
    frame_err = sof & (state_q == FR_OPEN);
    // a start strobe discards what earlier words accumulated
    err_now   = sof ? word_bad : (acc_q | word_bad);
    err       = last & err_now;
    state_d   = (take && bst) ? FR_OPEN : FR_IDLE;
    acc_d     = take ? err_now : acc_q;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      acc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      acc_q   <= acc_d;
    end
  end
endmodule

// File: rtl/brx_framer.sv
module brx_framer #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  localparam int NLANES = DATA_W / LANE_W
) (
  input  logic              bus_clk,
  input  logic              rst_n,
  input  logic              sof_n,
  input  logic              bst_n,
  input  logic              cpar_n,
  input  logic [DATA_W-1:0] bus_n,
  input  logic [NLANES-1:0] bpar_n,
  output logic              wd_valid,
  output logic              wd_first,
  output logic              wd_last,
  output logic [DATA_W-1:0] wd_data,
  output logic              wd_err,
  output logic              wd_frame_err
);
  logic              sof, bst, ctl_par;
  logic [DATA_W-1:0] data;
  logic [NLANES-1:0] lane_par;
  logic              word_bad;
  logic              take, first, last, err, frame_err;

  assign sof      = ~sof_n;
  assign bst      = ~bst_n;
  assign ctl_par  = ~cpar_n;
  assign data     = ~bus_n;
  assign lane_par = ~bpar_n;

  brx_par_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_par (
    .data     (data),
    .lane_par (lane_par),
    .sof      (sof),
    .bst      (bst),
    .ctl_par  (ctl_par),
    .word_bad (word_bad)
  );

  brx_seq u_seq (
    .clk       (bus_clk),
    .rst_n     (rst_n),
    .sof       (sof),
    .bst       (bst),
    .word_bad  (word_bad),
    .take      (take),
    .first     (first),
    .last      (last),
    .err       (err),
    .frame_err (frame_err)
  );

  always_ff @(negedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_valid     <= 1'b0;
      wd_first     <= 1'b0;
      wd_last      <= 1'b0;
      wd_err       <= 1'b0;
      wd_frame_err <= 1'b0;
    end else begin
      wd_valid     <= take;
      wd_first     <= first;
      wd_last      <= last;
      wd_err       <= err;
      wd_frame_err <= frame_err;
    end
  end

  // data register is enabled only when a word is framed
  always_ff @(negedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_data <= '0;
    end else if (take) begin
      wd_data <= data;
    end
  end
endmodule

// File: rtl/brx_framer_chk.sv
module brx_framer_chk #(
  parameter int DATA_W = 64
) (
  input logic              bus_clk,
  input logic              rst_n,
  input logic              sof_n,
  input logic              bst_n,
  input logic [DATA_W-1:0] bus_n,
  input logic              wd_valid,
  input logic              wd_first,
  input logic              wd_last,
  input logic [DATA_W-1:0] wd_data,
  input logic              wd_err,
  input logic              wd_frame_err
);
  assert_data_R2: assert property (@(negedge bus_clk) disable iff (!rst_n)
    !sof_n |=> (wd_valid && wd_data == ~$past(bus_n)));

  assert_start_first_R3: assert property (@(negedge bus_clk) disable iff (!rst_n)
    !sof_n |=> wd_first);

  assert_single_word_R3: assert property (@(negedge bus_clk) disable iff (!rst_n)
    (!sof_n && bst_n) |=> (wd_first && wd_last));

  assert_first_valid_R3: assert property (@(negedge bus_clk) disable iff (!rst_n)
    wd_first |-> wd_valid);

  assert_last_valid_R4: assert property (@(negedge bus_clk) disable iff (!rst_n)
    wd_last |-> wd_valid);

  assert_err_on_last_R7: assert property (@(negedge bus_clk) disable iff (!rst_n)
    wd_err |-> wd_last);

  assert_frame_on_first_R8: assert property (@(negedge bus_clk) disable iff (!rst_n)
    wd_frame_err |-> wd_first);

  assert_idle_quiet_R9: assert property (@(negedge bus_clk) disable iff (!rst_n)
    (sof_n && (!wd_valid || wd_last)) |=> !wd_valid);
endmodule

bind brx_framer brx_framer_chk #(.DATA_W(DATA_W)) u_chk (
  .bus_clk      (bus_clk),
  .rst_n        (rst_n),
  .sof_n        (sof_n),
  .bst_n        (bst_n),
  .bus_n        (bus_n),
  .wd_valid     (wd_valid),
  .wd_first     (wd_first),
  .wd_last      (wd_last),
  .wd_data      (wd_data),
  .wd_err       (wd_err),
  .wd_frame_err (wd_frame_err)
);

// File: tb/tb_brx_framer.sv
module tb_brx_framer;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 64;
  localparam int LANE_W = 8;
  localparam int NLANES = DATA_W / LANE_W;

  logic              clk;
  logic              rst_n;
  logic              sof_n, bst_n, cpar_n;
  logic [DATA_W-1:0] bus_n;
  logic [NLANES-1:0] bpar_n;
  logic              wd_valid, wd_first, wd_last, wd_err, wd_frame_err;
  logic [DATA_W-1:0] wd_data;

  int checks = 0;
  int errors = 0;

  brx_framer #(.DATA_W(DATA_W), .LANE_W(LANE_W)) dut (
    .bus_clk      (clk),
    .rst_n        (rst_n),
    .sof_n        (sof_n),
    .bst_n        (bst_n),
    .cpar_n       (cpar_n),
    .bus_n        (bus_n),
    .bpar_n       (bpar_n),
    .wd_valid     (wd_valid),
    .wd_first     (wd_first),
    .wd_last      (wd_last),
    .wd_data      (wd_data),
    .wd_err       (wd_err),
    .wd_frame_err (wd_frame_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // drive one cycle (logical values), inject parity flips, wait for next rising edge
  task automatic drive(input logic s, input logic b, input logic [DATA_W-1:0] d,
                       input logic [NLANES-1:0] flip, input logic cflip);
    logic [NLANES-1:0] p;
    for (int i = 0; i < NLANES; i++) p[i] = ~(^d[i*LANE_W +: LANE_W]) ^ flip[i];
    sof_n  = ~s;
    bst_n  = ~b;
    bus_n  = ~d;
    bpar_n = ~p;
    cpar_n = ~(~(s ^ b) ^ cflip);
    @(posedge clk);
  endtask

  task automatic expect_word(input string tag, input logic v, input logic f, input logic l,
                             input logic e, input logic fe, input logic [DATA_W-1:0] d);
    chk({tag, " valid"}, 64'(wd_valid), 64'(v));
    chk({tag, " first"}, 64'(wd_first), 64'(f));
    chk({tag, " last"},  64'(wd_last),  64'(l));
    chk({tag, " err"},   64'(wd_err),   64'(e));
    chk({tag, " frame"}, 64'(wd_frame_err), 64'(fe));
    if (v) chk({tag, " data"}, wd_data, d);
  endtask

  task automatic t_single;
    drive(1, 0, 64'h0123_4567_89AB_CDEF, '0, 0);
    expect_word("R3 R2 single", 1, 1, 1, 0, 0, 64'h0123_4567_89AB_CDEF);
    drive(0, 0, '0, '0, 0);
    expect_word("R4 after single idle", 0, 0, 0, 0, 0, '0);
  endtask

  task automatic t_burst;
    drive(1, 1, 64'hA5A5_0000_FFFF_1111, '0, 0);
    expect_word("R4 burst w0", 1, 1, 0, 0, 0, 64'hA5A5_0000_FFFF_1111);
    drive(0, 1, 64'h1, '0, 0);
    expect_word("R4 burst w1", 1, 0, 0, 0, 0, 64'h1);
    drive(0, 1, 64'hFFFF_FFFF_FFFF_FFFF, '0, 0);
    expect_word("R4 burst w2", 1, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    drive(0, 0, 64'h8000_0000_0000_0000, '0, 0);
    expect_word("R4 burst w3 last", 1, 0, 1, 0, 0, 64'h8000_0000_0000_0000);
    drive(0, 0, 64'h5, '0, 0);
    expect_word("R4 burst ended", 0, 0, 0, 0, 0, '0);
  endtask

  task automatic t_lane_err;
    drive(1, 1, 64'h1111, '0, 0);
    expect_word("R7 lane err w0", 1, 1, 0, 0, 0, 64'h1111);
    drive(0, 1, 64'h2222, 8'h20, 0);
    expect_word("R7 lane err w1 not reported", 1, 0, 0, 0, 0, 64'h2222);
    drive(0, 0, 64'h3333, '0, 0);
    expect_word("R5 R7 lane5 err on last", 1, 0, 1, 1, 0, 64'h3333);
    drive(1, 0, 64'h4444, '0, 0);
    expect_word("R7 cleared by start", 1, 1, 1, 0, 0, 64'h4444);
    drive(1, 0, 64'h0, 8'h01, 0);
    expect_word("R5 lane0 err", 1, 1, 1, 1, 0, 64'h0);
    drive(1, 0, 64'hFF00_0000_0000_0000, 8'h80, 0);
    expect_word("R5 lane7 err", 1, 1, 1, 1, 0, 64'hFF00_0000_0000_0000);
    drive(1, 1, 64'h7, 8'h04, 0);
    expect_word("R7 cmd err w0", 1, 1, 0, 0, 0, 64'h7);
    drive(0, 1, 64'h8, '0, 0);
    expect_word("R7 cmd err w1", 1, 0, 0, 0, 0, 64'h8);
    drive(0, 0, 64'h9, '0, 0);
    expect_word("R7 cmd err sticky to last", 1, 0, 1, 1, 0, 64'h9);
  endtask

  task automatic t_ctl_err;
    drive(1, 0, 64'hDEAD, '0, 1);
    expect_word("R6 ctl parity single", 1, 1, 1, 1, 0, 64'hDEAD);
    drive(1, 1, 64'hBEEF, '0, 0);
    expect_word("R6 burst w0", 1, 1, 0, 0, 0, 64'hBEEF);
    drive(0, 0, 64'hF00D, '0, 1);
    expect_word("R6 ctl parity on last", 1, 0, 1, 1, 0, 64'hF00D);
  endtask

  task automatic t_frame;
    drive(1, 1, 64'hA, '0, 0);
    expect_word("R8 old w0", 1, 1, 0, 0, 0, 64'hA);
    drive(0, 1, 64'hB, 8'h10, 0);
    expect_word("R8 old w1", 1, 0, 0, 0, 0, 64'hB);
    drive(1, 1, 64'hC, '0, 0);
    expect_word("R8 restart frame err", 1, 1, 0, 0, 1, 64'hC);
    drive(0, 0, 64'hD, '0, 0);
    expect_word("R8 new transaction ends clean", 1, 0, 1, 0, 0, 64'hD);
  endtask

  task automatic t_idle;
    drive(0, 1, 64'hFFFF, 8'hFF, 1);
    expect_word("R9 stray burst idle", 0, 0, 0, 0, 0, '0);
    drive(0, 0, 64'h1234, 8'h0F, 1);
    expect_word("R9 bad parity idle", 0, 0, 0, 0, 0, '0);
    drive(1, 0, 64'h55, '0, 0);
    expect_word("R9 no leak into next", 1, 1, 1, 0, 0, 64'h55);
  endtask

  initial begin
    rst_n = 1'b0;
    sof_n = 1'b1; bst_n = 1'b1; cpar_n = 1'b1;
    bus_n = '1;   bpar_n = '1;
    repeat (3) @(posedge clk);
    expect_word("R1 in reset", 0, 0, 0, 0, 0, '0);
    rst_n = 1'b1;
    drive(0, 0, '0, '0, 0);
    expect_word("R1 after reset", 0, 0, 0, 0, 0, '0);
    t_single();
    t_burst();
    t_lane_err();
    t_ctl_err();
    t_frame();
    t_idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired got 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule